// File: doc/BRIEF.md
# Vicinity-card tag response encoder

This block builds the load-modulation pattern that a vicinity card (ISO 15693 style) puts on the reader field when it answers. A frame request carries a byte count, the tick on which the reader's end-of-frame was seen, and a slow-mode flag. The bytes then arrive one per handshake and go into a local store. The block works out when the answer must start, waits for a free-running tick counter supplied from outside to reach that point, and then drives one subcarrier-enable bit per subcarrier period (fc/32 tick).

The answer is made of half-bit slots. Each slot is either eight subcarrier periods of modulation or the same length of silence. A fixed start-of-frame slot pattern comes first, then the data in Manchester form, least significant bit first, then a fixed end-of-frame pattern. The start is aligned to an 8-tick word of the counter, and the low three bits of the scheduled time shift the whole stream by that many ticks inside the word. In slow mode every slot lasts four times as long. The subcarrier itself, the CRC and the analog front end are handled elsewhere.

Top module: `vresp_encoder`

## Requirements
- R1: After reset, mod_out, busy and byte_ready are all 0.
- R2: A frame request (start_valid) is taken only while busy is 0. Busy goes high on the next cycle and stays high until the end of the frame. A request made while busy has no effect on the output. byte_ready is 1 exactly while the frame still waits for bytes, and each cycle with byte_valid and byte_ready takes one byte.
- R3: The scheduled time is rdr_eof_tick + 131 (a turnaround of 132 ticks less one tick of compensation), modulo the counter width. The frame window opens on the first tick_en cycle after all bytes are loaded where tick_count equals the scheduled time with its low three bits cleared. If that value has already passed, the block waits until the counter wraps around to it.
- R4: If d is the low three bits of the scheduled time, the first d ticks of the window carry no modulation.
- R5: Each half-bit slot lasts 8 ticks, or 32 ticks when slow_mode was 1 at the request.
- R6: The start-of-frame slots are 0,0,0,1,1,1,0,1 in time order (1 = modulated).
- R7: Data bytes go out in load order, each one least significant bit first. A data 1 becomes the slot pair 0 then 1, and a data 0 becomes 1 then 0.
- R8: The end-of-frame slots are 1,0,1,1,1,0,0,0 in time order.
- R9: After the end-of-frame there are 8-d unmodulated flush ticks. The window therefore lasts 8*(slots*rep+1) ticks, where rep is 1, or 4 in slow mode. Busy falls on the tick of the last flush tick, and mod_out is 0 whenever busy is 0.
- R10: A frame of length 0 never raises byte_ready and sends the start-of-frame followed directly by the end-of-frame.
- R11: mod_out changes only on cycles with tick_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle strobe per subcarrier period |
| tick_count | input | TICK_W | Free-running tick counter, valid on tick_en |
| rdr_eof_tick | input | TICK_W | Tick at which the reader's end-of-frame was seen |
| slow_mode | input | 1 | 1 stretches every slot four times |
| frame_len | input | LEN_W | Number of data bytes (clamped to MAX_LEN) |
| start_valid | input | 1 | Frame request strobe |
| byte_valid | input | 1 | Data byte present |
| byte_data | input | 8 | Data byte |
| byte_ready | output | 1 | Block accepts a data byte this cycle |
| busy | output | 1 | A frame is in progress |
| mod_out | output | 1 | Subcarrier enable for the current tick |

## Verification
The case that is hardest to reach from the ports is a frame whose aligned start passes while its bytes are still missing. The block must not start late inside that word. It has to wait a full counter wrap instead. The bench reaches this case by instantiating the block with a 10-bit counter, holding back the only byte of a one-byte frame for 200 cycles, and expecting the window to open about one wrap later. The reference model also covers every shift offset from 0 to 7 across fast, slow, empty and multi-byte frames, and a slow frame whose window runs across a counter wrap.

// File: rtl/vresp_pkg.sv
package vresp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ARMED,
    ST_LEAD,
    ST_SLOT,
    ST_TAIL
  } vresp_state_e;

  // bit i holds half-bit slot i (slot 0 is sent first)
  localparam logic [7:0] SOF_PAT = 8'hB8;
  localparam logic [7:0] EOF_PAT = 8'h1D;

  // ticks per half-bit slot is fixed at 8: the start is aligned to 8-tick words
  localparam int SUB_BITS = 3;

endpackage

// File: rtl/vresp_rst_sync.sv
module vresp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/vresp_byte_store.sv
module vresp_byte_store #(
  parameter int MAX_LEN = 16,
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0] mem_q [MAX_LEN];

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        mem_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/vresp_symbol_map.sv
module vresp_symbol_map
  import vresp_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5,
  parameter int SLOT_W  = 9,
  parameter int IDX_W   = 4
) (
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [LEN_W-1:0]  len,
  input  logic [7:0]        byte_val,
  output logic [IDX_W-1:0]  byte_idx,
  output logic              half_bit,
  output logic              last_slot
);
  logic [SLOT_W-1:0] data_slots;
  logic [SLOT_W-1:0] rel;
  logic [2:0]        bit_pos;

  assign data_slots = SLOT_W'(len) << 4;
  assign rel        = slot_idx - SLOT_W'(8);
  assign bit_pos    = rel[3:1];
  assign byte_idx   = rel[IDX_W+3:4];
  assign last_slot  = (slot_idx == (data_slots + SLOT_W'(15)));

  // SOF and EOF both begin on a multiple of 8, so the low 3 bits select the pattern bit
  always_comb begin
    if (slot_idx < SLOT_W'(8)) begin
      half_bit = SOF_PAT[slot_idx[2:0]];
    end else if (rel < data_slots) begin
      half_bit = rel[0] ? byte_val[bit_pos] : ~byte_val[bit_pos];
    end else begin
      half_bit = EOF_PAT[slot_idx[2:0]];
    end
  end
endmodule

// File: rtl/vresp_encoder.sv
module vresp_encoder
  import vresp_pkg::*;
#(
  parameter int MAX_LEN    = 16,
  parameter int TICK_W     = 16,
  parameter int TURNAROUND = 132,
  parameter int PIPE_COMP  = 1,
  parameter int SLOW_REP   = 4,
  localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [TICK_W-1:0] tick_count,
  input  logic [TICK_W-1:0] rdr_eof_tick,
  input  logic              slow_mode,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              start_valid,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  output logic              busy,
  output logic              mod_out
);
  localparam int IDX_W  = $clog2(MAX_LEN);
  localparam int SLOT_W = $clog2(16 * MAX_LEN + 16);
  localparam int SUB_W  = $clog2((1 << SUB_BITS) * SLOW_REP);
  localparam int CNT_W  = SUB_BITS + 1;

  logic rst_sync_n;

  vresp_state_e      state_q, state_d, eff_state;
  logic [LEN_W-1:0]  len_q, len_d, len_eff;
  logic [TICK_W-1:0] start_q, start_d, sched;
  logic [SUB_BITS-1:0] off_q, off_d;
  logic              slow_q, slow_d;
  logic [LEN_W-1:0]  wr_idx_q, wr_idx_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [SUB_W-1:0]  sub_q, sub_d, last_sub;
  logic [CNT_W-1:0]  cnt_q, cnt_d, eff_cnt;
  logic              mod_q, mod_d;

  logic              byte_acc, hit, run_tick;
  logic [IDX_W-1:0]  rd_idx;
  logic [7:0]        rd_byte;
  logic              half_bit, last_slot;

  vresp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vresp_byte_store #(.MAX_LEN(MAX_LEN)) u_store (
    .clk     (clk),
    .wr_en   (byte_acc),
    .wr_idx  (wr_idx_q[IDX_W-1:0]),
    .wr_data (byte_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_byte)
  );

  vresp_symbol_map #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W),
    .SLOT_W  (SLOT_W),
    .IDX_W   (IDX_W)
  ) u_map (
    .slot_idx  (slot_q),
    .len       (len_q),
    .byte_val  (rd_byte),
    .byte_idx  (rd_idx),
    .half_bit  (half_bit),
    .last_slot (last_slot)
  );

  assign sched    = rdr_eof_tick + TICK_W'(TURNAROUND - PIPE_COMP);
  assign len_eff  = (frame_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : frame_len;
  assign last_sub = slow_q ? SUB_W'((1 << SUB_BITS) * SLOW_REP - 1)
                           : SUB_W'((1 << SUB_BITS) - 1);
  assign byte_acc = byte_valid && (state_q == ST_FILL);
  assign hit      = tick_en && (state_q == ST_ARMED) && (tick_count == start_q);
  assign run_tick = hit || (tick_en && ((state_q == ST_LEAD) ||
                                        (state_q == ST_SLOT) ||
                                        (state_q == ST_TAIL)));

  // next-state logic
  always_comb begin
    state_d  = state_q;
    len_d    = len_q;
    start_d  = start_q;
    off_d    = off_q;
    slow_d   = slow_q;
    wr_idx_d = wr_idx_q;
    slot_d   = slot_q;
    sub_d    = sub_q;
    cnt_d    = cnt_q;
    mod_d    = mod_q;

    // the aligning tick is handled as the first tick of the lead-in
    eff_state = hit ? ST_LEAD : state_q;
    eff_cnt   = hit ? {1'b0, off_q} : cnt_q;
    if ((eff_state == ST_LEAD) && (eff_cnt == '0)) begin
      eff_state = ST_SLOT;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (start_valid) begin
          len_d    = len_eff;
          start_d  = {sched[TICK_W-1:SUB_BITS], {SUB_BITS{1'b0}}};
          off_d    = sched[SUB_BITS-1:0];
          slow_d   = slow_mode;
          wr_idx_d = '0;
          slot_d   = '0;
          sub_d    = '0;
          state_d  = (len_eff == '0) ? ST_ARMED : ST_FILL;
        end
      end
      ST_FILL: begin
        if (byte_valid) begin
          wr_idx_d = wr_idx_q + 1'b1;
          if (wr_idx_q == (len_q - 1'b1)) begin
            state_d = ST_ARMED;
          end
        end
      end
      default: begin
        if (run_tick) begin
          unique case (eff_state)
            ST_LEAD: begin
              mod_d   = 1'b0;
              cnt_d   = eff_cnt - 1'b1;
              state_d = ST_LEAD;
            end
            ST_SLOT: begin
              mod_d   = half_bit;
              state_d = ST_SLOT;
              if (sub_q == last_sub) begin
                sub_d = '0;
                if (last_slot) begin
                  state_d = ST_TAIL;
                  cnt_d   = CNT_W'(1 << SUB_BITS) - {1'b0, off_q};
                end else begin
                  slot_d = slot_q + 1'b1;
                end
              end else begin
                sub_d = sub_q + 1'b1;
              end
            end
            ST_TAIL: begin
              mod_d = 1'b0;
              cnt_d = cnt_q - 1'b1;
              if (cnt_q == CNT_W'(1)) begin
                state_d = ST_IDLE;
              end
            end
            default: begin
            end
          endcase
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      len_q    <= '0;
      start_q  <= '0;
      off_q    <= '0;
      slow_q   <= 1'b0;
      wr_idx_q <= '0;
      slot_q   <= '0;
      sub_q    <= '0;
      cnt_q    <= '0;
      mod_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      len_q    <= len_d;
      start_q  <= start_d;
      off_q    <= off_d;
      slow_q   <= slow_d;
      wr_idx_q <= wr_idx_d;
      slot_q   <= slot_d;
      sub_q    <= sub_d;
      cnt_q    <= cnt_d;
      mod_q    <= mod_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign byte_ready = (state_q == ST_FILL);
  assign mod_out    = mod_q;
endmodule

// File: rtl/vresp_encoder_chk.sv
module vresp_encoder_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             start_valid,
  input logic [LEN_W-1:0] frame_len,
  input logic             busy,
  input logic             byte_ready,
  input logic             mod_out
);
  // R11
  held_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(mod_out));

  // R9
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mod_out);

  // R9
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick_en));

  // R2
  ready_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> busy);

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !busy) |=> busy);

  // R10
  empty_frame_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !busy && (frame_len == '0)) |=> !byte_ready);
endmodule

bind vresp_encoder vresp_encoder_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_en     (tick_en),
  .start_valid (start_valid),
  .frame_len   (frame_len),
  .busy        (busy),
  .byte_ready  (byte_ready),
  .mod_out     (mod_out)
);

// File: tb/vresp_encoder_bench.sv
module vresp_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW         = 10;
  localparam int WRAP       = 1 << TW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_en;
  logic [TW-1:0] tick_count;
  logic [TW-1:0] rdr_eof_tick;
  logic          slow_mode;
  logic [4:0]    frame_len;
  logic          start_valid;
  logic          byte_valid;
  logic [7:0]    byte_data;
  logic          byte_ready;
  logic          busy;
  logic          mod_out;

  vresp_encoder #(.TICK_W(TW)) u_vresp_encoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .tick_count   (tick_count),
    .rdr_eof_tick (rdr_eof_tick),
    .slow_mode    (slow_mode),
    .frame_len    (frame_len),
    .start_valid  (start_valid),
    .byte_valid   (byte_valid),
    .byte_data    (byte_data),
    .byte_ready   (byte_ready),
    .busy         (busy),
    .mod_out      (mod_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 0;

  // reference model state
  int m_st = 0;            // 0 idle, 1 waiting bytes, 2 waiting time, 3 window
  int m_len, m_got, m_start, m_d, m_rep, m_k, m_len_win;
  bit q_slots[$];
  bit exp_mod = 0;
  bit prev_mod = 0;
  byte fb[16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d (window tick %0d)", tag, act, exp, m_k);
    end
  endtask

  task automatic push_seq(input bit [7:0] seq);
    for (int i = 7; i >= 0; i--) q_slots.push_back(seq[i]);
  endtask

  function automatic bit win_val(input int k);
    int j;
    if (k < m_d) return 1'b0;
    j = (k - m_d) / (8 * m_rep);
    if (j < q_slots.size()) return q_slots[j];
    return 1'b0;
  endfunction

  function automatic string win_tag(input int k);
    string t;
    int j;
    if (m_st != 3 && m_k < 0) t = "R2";
    else if (k < m_d) t = "R4";
    else begin
      j = (k - m_d) / (8 * m_rep);
      if (j < 8) t = "R5 R6";
      else if (j < 8 + 16 * m_len) t = "R5 R7";
      else if (j < q_slots.size()) t = "R5 R8";
      else t = "R9";
    end
    if (k == 0) t = {t, " R3"};
    if (m_len == 0) t = {t, " R10"};
    return t;
  endfunction

  task automatic arm();
    push_seq(8'b1011_1000);   // end-of-frame, time order
    m_st = 2;
  endtask

  // model step, comparison and tick generation, all away from the rising edge
  always @(negedge clk) begin
    int sched;
    cyc++;
    if (rst_n) begin
      case (m_st)
        0: if (start_valid) begin
             sched   = (int'(rdr_eof_tick) + 131) % WRAP;
             m_start = sched & ~7;
             m_d     = sched & 7;
             m_rep   = slow_mode ? 4 : 1;
             m_len   = (frame_len > 16) ? 16 : int'(frame_len);
             m_got   = 0;
             m_k     = -1;
             q_slots.delete();
             push_seq(8'b0001_1101);  // start-of-frame, time order
             if (m_len == 0) arm(); else m_st = 1;
           end
        1: if (byte_valid) begin
             for (int b = 0; b < 8; b++) begin
               q_slots.push_back(~byte_data[b]);
               q_slots.push_back(byte_data[b]);
             end
             m_got++;
             if (m_got == m_len) arm();
           end
        2: if (tick_en && int'(tick_count) == m_start) begin
             m_st      = 3;
             m_k       = 0;
             m_len_win = 8 * (q_slots.size() * m_rep + 1);
             exp_mod   = win_val(0);
             if (m_len_win == 1) m_st = 0;
           end
        default: if (tick_en) begin
             m_k++;
             exp_mod = win_val(m_k);
             if (m_k == m_len_win - 1) m_st = 0;
           end
      endcase
      if (!(m_st == 3 || (m_st == 0 && m_k >= 0 && m_k == m_len_win - 1 && tick_en)))
        if (m_st != 3 && !(m_k == m_len_win - 1)) exp_mod = 0;
      chk(mod_out == exp_mod, win_tag(m_k < 0 ? 0 : m_k), mod_out, exp_mod);
      chk(busy == (m_st != 0), "R2 R9 busy", busy, m_st != 0);
      chk(byte_ready == (m_st == 1), "R2 byte_ready", byte_ready, m_st == 1);
      if (!tick_en) chk(mod_out == prev_mod, "R11 hold between ticks", mod_out, prev_mod);
    end
    prev_mod = mod_out;
    if (tick_en) tick_count = tick_count + 1'b1;
    tick_en = ~tick_en;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic wait_idle();
    step();
    while (busy) step();
    repeat (3) step();
  endtask

  task automatic send_frame(input int len, input int d, input bit slow,
                            input int hold, input bit poke_busy);
    int sched;
    sched        = ((int'(tick_count) + 48) & ~7) + d;
    rdr_eof_tick = TW'((sched - 131 + 4 * WRAP) % WRAP);
    frame_len    = 5'(len);
    slow_mode    = slow;
    start_valid  = 1'b1;
    step();
    start_valid  = 1'b0;
    repeat (hold) step();
    for (int i = 0; i < len; i++) begin
      byte_valid = 1'b1;
      byte_data  = fb[i];
      step();
    end
    byte_valid = 1'b0;
    if (poke_busy) begin
      // R2: request while busy must be ignored
      step();
      slow_mode   = ~slow;
      frame_len   = 5'd0;
      start_valid = 1'b1;
      step();
      start_valid = 1'b0;
    end
    wait_idle();
  endtask

  initial begin
    rst_n        = 1'b0;
    tick_en      = 1'b0;
    tick_count   = '0;
    rdr_eof_tick = '0;
    slow_mode    = 1'b0;
    frame_len    = '0;
    start_valid  = 1'b0;
    byte_valid   = 1'b0;
    byte_data    = '0;
    repeat (3) step();
    // R1: reset state
    chk(mod_out == 1'b0, "R1 mod_out", mod_out, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(byte_ready == 1'b0, "R1 byte_ready", byte_ready, 0);
    rst_n = 1'b1;
    repeat (6) step();

    fb[0] = 8'hA5; fb[1] = 8'h01; fb[2] = 8'hFF;
    send_frame(3, 0, 1'b0, 0, 1'b0);          // R7 several byte patterns, no offset
    fb[0] = 8'h3C; fb[1] = 8'h80;
    send_frame(2, 5, 1'b0, 0, 1'b1);          // R4 offset 5, R2 ignored request
    fb[0] = 8'h6E;
    send_frame(1, 3, 1'b1, 0, 1'b0);          // R5 slow mode, window crosses a wrap
    send_frame(0, 7, 1'b0, 0, 1'b0);          // R10 empty frame, offset 7
    fb[0] = 8'h00;
    send_frame(1, 2, 1'b0, 200, 1'b0);        // R3 aligned start missed, waits a wrap
    fb[0] = 8'hC3; fb[1] = 8'h5A; fb[2] = 8'h0F; fb[3] = 8'hF0;
    send_frame(4, 1, 1'b0, 0, 1'b0);
    send_frame(0, 6, 1'b1, 0, 1'b0);          // R10 empty frame in slow mode

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end
endmodule